// File: doc/BRIEF.md
# Host-Target Mailbox Command Decoder

This block gives software on a target processor a two-register channel to a host-side harness. Each register is 64 bits wide and is reached as two 32-bit words over a simple register bus. Software posts a command in the command register. The write to its upper word commits the command. The block then splits the command into a device number, a command code and a 48-bit payload, and acts on it.

There are three actions. The block can signal a test exit with its exit code, send one console character, or remember that the target asked for console input. Each completed command leaves a reply in the response register and clears the command register. A character arriving from the host console fills the response register, tagged with the upper bits of the last console-read request. Software may also write the response register directly.

Top module: `hostlink_mailbox`

## Requirements
- R1: Address map. The command register's low word is at `CMD_BASE` and its high word at `CMD_BASE+4`. The response register's low word is at `RSP_BASE` and its high word at `RSP_BASE+4`. `reg_rdata` combinationally returns the addressed half, and 0 for any other address. After reset both registers read as zero.
- R2: A write to the command low word is accepted only when all 64 command bits are zero. The accepted write loads the word into bits [31:0] and clears bits [63:32]. Otherwise the write is dropped, and high-word command writes are ignored until a low-word write is accepted again.
- R3: An accepted write to the command high word ORs the data into bits [63:32] and decodes the combined 64-bit command. The fields are: device in [63:56], command code in [55:48], payload in [47:0].
- R4: Device 0 with code 0 and payload bit 0 set produces `exit_valid` for exactly one cycle, in the cycle after the commit edge. In that cycle `exit_code` equals payload[47:1].
- R5: Device 1 with code 1 produces `cons_valid` for exactly one cycle, with `cons_byte` equal to payload[7:0]. The reply value is 0x100 OR the byte.
- R6: Device 1 with code 0 records bits [63:48] of the command as the pending read request and clears the command register. The response register is left unchanged.
- R7: Every other commit sets the response register to the command's bits [63:48] above the 48-bit reply value, and clears the command register. The reply value is 0 for every device and code other than device 1 code 1, including the exit command.
- R8: A pulse on `rx_valid` sets the response register to {pending[15:0], 39'b0, 1'b1, rx_byte}, so the low 48 bits are 0x100 OR the byte. The pending field is 0 after reset.
- R9: A write to the response low word replaces the whole register with the zero-extended word. A write to the response high word ORs the data into bits [63:32].
- R10: When `rx_valid` and a response-register write fall in the same cycle, the receive update is applied first and the bus write second. A low-word write therefore wins outright.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the 32-bit word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| rx_valid | input | 1 | A console character is arriving |
| rx_byte | input | 8 | The arriving console character |
| exit_valid | output | 1 | One-cycle test-exit event |
| exit_code | output | 47 | Exit code, valid with `exit_valid` |
| cons_valid | output | 1 | One-cycle console output event |
| cons_byte | output | 8 | Console character, valid with `cons_valid` |

## Verification
The bench sweeps every combination of three device numbers, three command codes and both settings of payload bit 0. For each combination it compares pulses, the response and the cleared command against values it computes itself. A decoder that mixes up the fields, fires on an even exit payload, or writes a reply for a read request fails that sweep. The bench also posts a second low word over a live command and then a high word. A design that accepts either write, or that unlocks the command register again, shows a changed command or a spurious console pulse. Console receive is exercised with and without a pending request, and together with a response write in the same cycle. A design with the wrong tag source or the wrong update order leaves a different response value.

// File: rtl/hl_mbox_pkg.sv
package hl_mbox_pkg;

    localparam int WORD_W = 32;
    localparam int MBOX_W = 64;
    localparam int DEV_W  = 8;
    localparam int CODE_W = 8;
    localparam int PAY_W  = 48;
    localparam int EXIT_W = PAY_W - 1;
    localparam int TAG_W  = MBOX_W - PAY_W;
    localparam int CHAR_W = 8;

    // register windows, in the order the address map generates them
    localparam int NWIN       = 4;
    localparam int WIN_CMD_LO = 0;
    localparam int WIN_CMD_HI = 1;
    localparam int WIN_RSP_LO = 2;
    localparam int WIN_RSP_HI = 3;

    localparam logic [DEV_W-1:0]  DEV_CTRL  = 8'd0;
    localparam logic [DEV_W-1:0]  DEV_CONS  = 8'd1;
    localparam logic [CODE_W-1:0] CODE_EXIT = 8'd0;
    localparam logic [CODE_W-1:0] CODE_GET  = 8'd0;
    localparam logic [CODE_W-1:0] CODE_PUT  = 8'd1;

    // 0x100 OR a character, widened to the reply field
    localparam logic [PAY_W-1:0] REPLY_MARK = PAY_W'(9'h100);

    typedef struct packed {
        logic              pend;
        logic              exit_fire;
        logic              cons_fire;
        logic [PAY_W-1:0]  reply;
        logic [EXIT_W-1:0] code;
        logic [CHAR_W-1:0] ch;
    } dec_t;

    typedef struct packed {
        logic [MBOX_W-1:0] cmd;
        logic [MBOX_W-1:0] rsp;
        logic [TAG_W-1:0]  pend_tag;
        logic              allow;
        logic              exit_v;
        logic [EXIT_W-1:0] exit_code;
        logic              cons_v;
        logic [CHAR_W-1:0] cons_byte;
    } state_t;

endpackage

// File: rtl/hl_addr_map.sv
module hl_addr_map
    import hl_mbox_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CMD_BASE = 'h00,
    parameter logic [ADDR_W-1:0] RSP_BASE = 'h08
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NWIN-1:0]   hit
);

    for (genvar i = 0; i < NWIN; i++) begin : g_win
        localparam logic [ADDR_W-1:0] BASE = (i < 2) ? CMD_BASE : RSP_BASE;
        localparam logic [ADDR_W-1:0] WADR = BASE + ADDR_W'((i % 2) * 4);
        assign hit[i] = (addr == WADR);
    end

endmodule

// File: rtl/hl_cmd_decode.sv
module hl_cmd_decode
    import hl_mbox_pkg::*;
(
    input  logic [MBOX_W-1:0] cmd,
    output dec_t              dec
);

    logic [DEV_W-1:0]  dev;
    logic [CODE_W-1:0] code;
    logic [PAY_W-1:0]  pay;

    assign dev  = cmd[MBOX_W-1 -: DEV_W];
    assign code = cmd[MBOX_W-DEV_W-1 -: CODE_W];
    assign pay  = cmd[PAY_W-1:0];

    always_comb begin
        dec      = '0;
        dec.code = pay[PAY_W-1:1];
        dec.ch   = pay[CHAR_W-1:0];
        if (dev == DEV_CTRL && code == CODE_EXIT) begin
            dec.exit_fire = pay[0];
        end else if (dev == DEV_CONS && code == CODE_PUT) begin
            dec.cons_fire = 1'b1;
            dec.reply     = REPLY_MARK | PAY_W'(pay[CHAR_W-1:0]);
        end else if (dev == DEV_CONS && code == CODE_GET) begin
            dec.pend = 1'b1;
        end
    end

endmodule

// File: rtl/hl_read_mux.sv
module hl_read_mux
    import hl_mbox_pkg::*;
(
    input  logic [NWIN-1:0]   hit,
    input  logic [MBOX_W-1:0] cmd,
    input  logic [MBOX_W-1:0] rsp,
    output logic [WORD_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        if (hit[WIN_CMD_LO]) rdata = cmd[WORD_W-1:0];
        if (hit[WIN_CMD_HI]) rdata = cmd[MBOX_W-1:WORD_W];
        if (hit[WIN_RSP_LO]) rdata = rsp[WORD_W-1:0];
        if (hit[WIN_RSP_HI]) rdata = rsp[MBOX_W-1:WORD_W];
    end

endmodule

// File: rtl/hostlink_mailbox.sv
module hostlink_mailbox
    import hl_mbox_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CMD_BASE = 'h00,
    parameter logic [ADDR_W-1:0] RSP_BASE = 'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              exit_valid,
    output logic [46:0]       exit_code,
    output logic              cons_valid,
    output logic [7:0]        cons_byte
);

    state_t            q;
    state_t            d;
    logic [NWIN-1:0]   hit;
    logic [MBOX_W-1:0] full_cmd;
    dec_t              dec;

    hl_addr_map #(
        .ADDR_W   (ADDR_W),
        .CMD_BASE (CMD_BASE),
        .RSP_BASE (RSP_BASE)
    ) u_map (
        .addr (reg_addr),
        .hit  (hit)
    );

    // command as it stands once the high word is merged in
    assign full_cmd = q.cmd | {reg_wdata, {WORD_W{1'b0}}};

    hl_cmd_decode u_dec (
        .cmd (full_cmd),
        .dec (dec)
    );

    hl_read_mux u_rd (
        .hit   (hit),
        .cmd   (q.cmd),
        .rsp   (q.rsp),
        .rdata (reg_rdata)
    );

    always_comb begin
        d        = q;
        d.exit_v = 1'b0;
        d.cons_v = 1'b0;

        // console receive first, so a bus write in the same cycle lands on top
        if (rx_valid) begin
            d.rsp = {q.pend_tag, REPLY_MARK | PAY_W'(rx_byte)};
        end

        if (reg_we) begin
            if (hit[WIN_CMD_LO]) begin
                if (q.cmd == '0) begin
                    d.allow = 1'b1;
                    d.cmd   = {{WORD_W{1'b0}}, reg_wdata};
                end else begin
                    d.allow = 1'b0;
                end
            end

            if (hit[WIN_CMD_HI] && q.allow) begin
                d.cmd = '0;
                if (dec.pend) begin
                    d.pend_tag = full_cmd[MBOX_W-1:PAY_W];
                end else begin
                    d.rsp    = {full_cmd[MBOX_W-1:PAY_W], dec.reply};
                    d.exit_v = dec.exit_fire;
                    d.cons_v = dec.cons_fire;
                    if (dec.exit_fire) d.exit_code = dec.code;
                    if (dec.cons_fire) d.cons_byte = dec.ch;
                end
            end

            if (hit[WIN_RSP_LO]) begin
                d.rsp = {{WORD_W{1'b0}}, reg_wdata};
            end
            if (hit[WIN_RSP_HI]) begin
                d.rsp = d.rsp | {reg_wdata, {WORD_W{1'b0}}};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign exit_valid = q.exit_v;
    assign exit_code  = q.exit_code;
    assign cons_valid = q.cons_v;
    assign cons_byte  = q.cons_byte;

endmodule

// File: rtl/hl_mbox_chk.sv
module hl_mbox_chk #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CMD_BASE = 'h00,
    parameter logic [ADDR_W-1:0] RSP_BASE = 'h08
) (
    input logic              clk,
    input logic              rst_n,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic              rx_valid,
    input logic [7:0]        rx_byte,
    input logic              exit_valid,
    input logic              cons_valid,
    input logic [7:0]        cons_byte,
    input logic [63:0]       cmd,
    input logic [63:0]       rsp,
    input logic              allow
);

    localparam logic [ADDR_W-1:0] CMD_HI = CMD_BASE + ADDR_W'(4);
    localparam logic [ADDR_W-1:0] RSP_HI = RSP_BASE + ADDR_W'(4);

    logic bus_hits_rsp;
    assign bus_hits_rsp = we && (addr == RSP_BASE || addr == RSP_HI || addr == CMD_HI);

    // R4 R5: one decode never fires both events
    p_one_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({exit_valid, cons_valid}));

    // R2: a refused low write leaves the command untouched
    p_low_refused_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == CMD_BASE && cmd != 64'd0) |=> $stable(cmd));

    // R2: a high write without permission is ignored
    p_high_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == CMD_HI && !allow) |=> $stable(cmd));

    // R7: an exit event comes with a cleared command register
    p_exit_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exit_valid |-> (cmd == 64'd0));

    // R5: the reply matches the character sent
    p_cons_reply_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cons_valid |-> (rsp[8:0] == {1'b1, cons_byte}));

    // R8: a received character lands in the reply
    p_rx_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !bus_hits_rsp) |=> (rsp[8:0] == {1'b1, $past(rx_byte)}));

    // R9 R10: a low response write replaces everything, even against a receive
    p_rsp_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == RSP_BASE) |=> (rsp == {32'd0, $past(wdata)}));

endmodule

bind hostlink_mailbox hl_mbox_chk #(
    .ADDR_W   (ADDR_W),
    .CMD_BASE (CMD_BASE),
    .RSP_BASE (RSP_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (reg_we),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .exit_valid (exit_valid),
    .cons_valid (cons_valid),
    .cons_byte  (cons_byte),
    .cmd        (q.cmd),
    .rsp        (q.rsp),
    .allow      (q.allow)
);

// File: tb/hostlink_mailbox_tb.sv
module hostlink_mailbox_tb;

    localparam int         CLK_PERIOD = 10;
    localparam logic [7:0] A_CMD_LO   = 8'h00;
    localparam logic [7:0] A_CMD_HI   = 8'h04;
    localparam logic [7:0] A_RSP_LO   = 8'h08;
    localparam logic [7:0] A_RSP_HI   = 8'h0C;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        rx_valid;
    logic [7:0]  rx_byte;
    logic        exit_valid;
    logic [46:0] exit_code;
    logic        cons_valid;
    logic [7:0]  cons_byte;

    int checks = 0;
    int errors = 0;

    logic        cap_exit, cap_cons;
    logic [46:0] cap_code;
    logic [7:0]  cap_byte;
    logic [63:0] rsp_m;
    logic [15:0] pend_m;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hostlink_mailbox #(
        .ADDR_W   (8),
        .CMD_BASE (8'h00),
        .RSP_BASE (8'h08)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .exit_valid (exit_valid),
        .exit_code  (exit_code),
        .cons_valid (cons_valid),
        .cons_byte  (cons_byte)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; reg_we = 1'b0; rx_valid = 1'b0;
        reg_addr = '0; reg_wdata = '0; rx_byte = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        rsp_m  = '0;
        pend_m = '0;
    endtask

    task automatic step(input logic we, input logic [7:0] a, input logic [31:0] dta,
                        input logic rxv, input logic [7:0] b);
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = dta; rx_valid = rxv; rx_byte = b;
        @(posedge clk);
        #1;
        cap_exit = exit_valid; cap_code = exit_code;
        cap_cons = cons_valid; cap_byte = cons_byte;
        reg_we = 1'b0; rx_valid = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic chk_reg(input logic [7:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        rd(a, v);
        chk(v == exp, req, {32'd0, v}, {32'd0, exp});
    endtask

    task automatic chk_rsp(input string req);
        chk_reg(A_RSP_LO, rsp_m[31:0], req);
        chk_reg(A_RSP_HI, rsp_m[63:32], req);
    endtask

    task automatic chk_quiet(input string req);
        @(posedge clk);
        #1;
        chk(!exit_valid && !cons_valid, req, {62'd0, exit_valid, cons_valid}, 64'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        do_reset();

        // R1: reset state and address map
        chk_reg(A_CMD_LO, 32'd0, "R1 cmd lo at reset");
        chk_reg(A_CMD_HI, 32'd0, "R1 cmd hi at reset");
        chk_rsp("R1 rsp at reset");
        chk_reg(8'h10, 32'd0, "R1 unmapped read");
        chk_quiet("R4 no pulse at reset");

        // R8: receive before any pending request carries a zero tag
        step(1'b0, 8'h00, 32'd0, 1'b1, 8'h7E);
        rsp_m = {16'd0, 48'h100 | 48'h7E};
        chk_rsp("R8 rx without pending");

        // R3 R4 R5 R6 R7: sweep devices, codes and payload bit 0
        for (int dv = 0; dv < 3; dv++) begin
            for (int cd = 0; cd < 3; cd++) begin
                for (int pb = 0; pb < 2; pb++) begin
                    logic [31:0] lo, hi;
                    logic [63:0] full;
                    logic        e_exit, e_cons, e_pend;
                    lo = (32'h2468_ACE0 ^ (32'(dv) << 12)) | (32'(cd) << 4) | 32'(pb);
                    hi = {8'(dv), 8'(cd), 16'hC3A5 ^ {1'(pb), 15'd0}};
                    full = {hi, lo};
                    e_exit = (dv == 0) && (cd == 0) && (pb == 1);
                    e_cons = (dv == 1) && (cd == 1);
                    e_pend = (dv == 1) && (cd == 0);

                    step(1'b1, A_CMD_LO, lo, 1'b0, 8'd0);
                    chk_reg(A_CMD_LO, lo, "R2 low word accepted when empty");
                    chk_reg(A_CMD_HI, 32'd0, "R2 high half clear after low write");

                    step(1'b1, A_CMD_HI, hi, 1'b0, 8'd0);
                    chk(cap_exit == e_exit, "R4 exit pulse", {63'd0, cap_exit}, {63'd0, e_exit});
                    if (e_exit)
                        chk(cap_code == full[47:1], "R4 exit code", {17'd0, cap_code},
                            {17'd0, full[47:1]});
                    chk(cap_cons == e_cons, "R5 console pulse", {63'd0, cap_cons},
                        {63'd0, e_cons});
                    if (e_cons)
                        chk(cap_byte == full[7:0], "R5 console byte", {56'd0, cap_byte},
                            {56'd0, full[7:0]});

                    if (e_pend) pend_m = full[63:48];
                    else if (e_cons) rsp_m = {full[63:48], 48'h100 | {40'd0, full[7:0]}};
                    else rsp_m = {full[63:48], 48'd0};

                    chk_quiet("R4 R5 pulses last one cycle");
                    chk_reg(A_CMD_LO, 32'd0, "R7 cmd lo cleared");
                    chk_reg(A_CMD_HI, 32'd0, "R7 cmd hi cleared");
                    chk_rsp(e_pend ? "R6 rsp unchanged by read request" : "R7 reply value");
                end
            end
        end

        // R8: receive tagged by the pending request
        step(1'b0, 8'h00, 32'd0, 1'b1, 8'h5A);
        rsp_m = {pend_m, 48'h100 | 48'h5A};
        chk_rsp("R8 rx with pending tag");
        step(1'b0, 8'h00, 32'd0, 1'b1, 8'hFF);
        rsp_m = {pend_m, 48'h1FF};
        chk_rsp("R8 rx byte FF");

        // R10: receive and low response write together, the bus write wins
        step(1'b1, A_RSP_LO, 32'hDEAD_BEEF, 1'b1, 8'h33);
        rsp_m = {32'd0, 32'hDEAD_BEEF};
        chk_rsp("R10 bus write after rx");

        // R10: receive and high response write together, OR onto the rx value
        step(1'b1, A_RSP_HI, 32'h0000_0F00, 1'b1, 8'h44);
        rsp_m = {pend_m, 48'h144} | {32'h0000_0F00, 32'd0};
        chk_rsp("R10 high write ORs onto rx value");

        // R9: response writes
        step(1'b1, A_RSP_HI, 32'hF0F0_0000, 1'b0, 8'd0);
        rsp_m = rsp_m | {32'hF0F0_0000, 32'd0};
        chk_rsp("R9 high write ORs");
        step(1'b1, A_RSP_LO, 32'h0000_1234, 1'b0, 8'd0);
        rsp_m = 64'h0000_1234;
        chk_rsp("R9 low write replaces");

        // R2: refused low write, then ignored high write
        step(1'b1, A_CMD_LO, 32'h0000_0011, 1'b0, 8'd0);
        step(1'b1, A_CMD_LO, 32'h0000_0022, 1'b0, 8'd0);
        chk_reg(A_CMD_LO, 32'h11, "R2 low write refused while busy");
        step(1'b1, A_CMD_HI, 32'h0101_0000, 1'b0, 8'd0);
        chk(!cap_cons && !cap_exit, "R2 high write after refusal ignored",
            {62'd0, cap_exit, cap_cons}, 64'd0);
        chk_reg(A_CMD_LO, 32'h11, "R2 cmd lo kept");
        chk_reg(A_CMD_HI, 32'd0, "R2 cmd hi kept");
        chk_rsp("R2 rsp unchanged");

        // R1: reset clears a stuck command
        do_reset();
        rd(A_CMD_LO, v);
        chk(v == 32'd0, "R1 reset clears cmd", {32'd0, v}, 64'd0);
        chk_rsp("R1 reset clears rsp");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule